// File: doc/BRIEF.md
# Fieldbus Transmit Jabber Inhibitor

This block keeps a local fieldbus transmitter from holding the bus for too long. While the encoder reports that it is driving the line (`tx_active`), the block times how long the transmission has lasted without a break. The limit comes from an 8-bit timeout code. Each step of the code is worth one 2.048 ms unit, and a code of zero switches the guard off. An internal prescaler builds the unit from the system clock frequency, which is set by a parameter.

When the limit is reached, the block raises `tx_inhibit`, which forces the encoder off. At the same moment it raises the `cd` flag. Both stay high for a fixed quiet period, 3 s at default parameters, and during that period any transmit activity is ignored. When the quiet period ends, both outputs drop and the guard is armed again with a fresh timer.

The timeout code is loaded through a write strobe. A write takes effect only while the transmitter is idle, so the limit cannot change under a packet in flight.

Top module: `jabber_inhibitor`

## Requirements
- R1: While the stored timeout code is 0, `tx_inhibit` and `cd` stay low however long `tx_active` is held high.
- R2: With a nonzero code N, `tx_inhibit` rises on the clock edge at which `tx_active` has been sampled high on N × UNIT_CYCLES consecutive edges, and not one edge earlier. UNIT_CYCLES is the cycle count of 2.048 ms at the clock frequency set by CLK_KHZ.
- R3: `cd` rises together with `tx_inhibit` on the tripping edge.
- R4: After a trip, `tx_inhibit` and `cd` remain high for exactly QUIET_UNITS × UNIT_CYCLES clock edges and then both return low. QUIET_UNITS is QUIET_MS (default 3000) rounded up to whole 2.048 ms units.
- R5: Any edge with `tx_active` sampled low while armed clears the timer, so a later run must again last the full N × UNIT_CYCLES edges.
- R6: `tx_active` has no effect during the quiet period. If it is still high at release, timing restarts from zero on the edge after release.
- R7: A write (`cfg_we` high with `cfg_code`) is stored only when the block is armed and `tx_active` is low. A write during a transmission or during the quiet period is discarded.
- R8: After synchronous reset, `tx_inhibit` and `cd` are low and the stored code is 0, which means disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_active | input | 1 | Encoder is driving the bus |
| cfg_we | input | 1 | Strobe to load a new timeout code |
| cfg_code | input | 8 | Timeout code in 2.048 ms units, 0 = disabled |
| tx_inhibit | output | 1 | Forces the encoder off during the quiet period |
| cd | output | 1 | Flag raised for the duration of a jabber silence |

## Verification
The assertions place no constraint on `tx_active`; it may toggle on any edge. They take the stored code as changing only through an idle write, and the R7 property checks exactly that. Their run and quiet counters count edges as the requirements define them. The stimulus drives every input one nanosecond after a rising edge and holds it for whole cycles, so each run length the bench applies is an exact count of sampled edges. Reduced parameters (4 cycles per unit, 5 quiet units) let full codes up to 255 be exercised within the bench's cycle budget.

// File: rtl/jab_pkg.sv
package jab_pkg;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_QUIET = 1'b1
    } jab_state_e;

    typedef struct packed {
        logic en;
        logic clr;
    } tmr_ctl_t;

    // Clock cycles in one 2.048 ms unit at the given clock in kHz
    function automatic int unit_cycles(input int clk_khz);
        int c;
        c = (clk_khz * 2048) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    // Quiet period rounded up to whole 2.048 ms units
    function automatic int quiet_units(input int quiet_ms);
        int u;
        u = (quiet_ms * 1000 + 2047) / 2048;
        return (u < 1) ? 1 : u;
    endfunction

    function automatic int wide_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/jab_prescaler.sv
module jab_prescaler #(
    parameter int CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  jab_pkg::tmr_ctl_t ctl,
    output logic             unit_pulse
);
    localparam int PW = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [PW-1:0] LAST = PW'(CYC - 1);

    logic [PW-1:0] cnt_q;

    assign unit_pulse = ctl.en && !ctl.clr && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            cnt_q <= '0;
        end else if (ctl.en) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/jab_unit_counter.sv
module jab_unit_counter #(
    parameter int UW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    input  logic [UW-1:0] limit,
    output logic          done
);
    logic [UW-1:0] cnt_q;

    assign done = inc && !clr && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr || done) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/jab_ctrl.sv
module jab_ctrl
    import jab_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int UW      = 11,
    parameter int QUIET_U = 1465
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_active,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              unit_done,
    output tmr_ctl_t          tmr_ctl,
    output logic [UW-1:0]     limit,
    output logic [CODE_W-1:0] code_q,
    output logic              quiet
);
    jab_state_e state_q, state_d;
    logic armed, timing, idle;

    assign armed  = (state_q == ST_ARMED);
    assign idle   = armed && !tx_active;
    assign timing = armed && tx_active && (code_q != '0);

    always_comb begin
        tmr_ctl.en  = timing || !armed;
        tmr_ctl.clr = armed && !timing;
        limit       = armed ? UW'(code_q) : UW'(QUIET_U);
    end

    always_comb begin
        state_d = state_q;
        if (unit_done) begin
            state_d = armed ? ST_QUIET : ST_ARMED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ARMED;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            if (cfg_we && idle) code_q <= cfg_code;
        end
    end

    assign quiet = (state_q == ST_QUIET);
endmodule

// File: rtl/jabber_inhibitor.sv
module jabber_inhibitor
    import jab_pkg::*;
#(
    parameter int CLK_KHZ  = 125000,
    parameter int QUIET_MS = 3000,
    parameter int CODE_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_active,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_code,
    output logic              tx_inhibit,
    output logic              cd
);
    localparam int UNIT_CYCLES = unit_cycles(CLK_KHZ);
    localparam int QUIET_UNITS = quiet_units(QUIET_MS);
    localparam int UW = wide_of(CODE_W, $clog2(QUIET_UNITS + 1));

    tmr_ctl_t          tmr_ctl;
    logic              unit_pulse;
    logic              unit_done;
    logic [UW-1:0]     limit;
    logic [CODE_W-1:0] code_q;
    logic              quiet;

    jab_prescaler #(.CYC(UNIT_CYCLES)) u_pre (
        .clk        (clk),
        .rst        (rst),
        .ctl        (tmr_ctl),
        .unit_pulse (unit_pulse)
    );

    jab_unit_counter #(.UW(UW)) u_units (
        .clk   (clk),
        .rst   (rst),
        .clr   (tmr_ctl.clr),
        .inc   (unit_pulse),
        .limit (limit),
        .done  (unit_done)
    );

    jab_ctrl #(.CODE_W(CODE_W), .UW(UW), .QUIET_U(QUIET_UNITS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tx_active (tx_active),
        .cfg_we    (cfg_we),
        .cfg_code  (cfg_code),
        .unit_done (unit_done),
        .tmr_ctl   (tmr_ctl),
        .limit     (limit),
        .code_q    (code_q),
        .quiet     (quiet)
    );

    assign tx_inhibit = quiet;
    assign cd         = quiet;
endmodule

// File: rtl/jab_checker.sv
module jab_checker #(
    parameter int CODE_W      = 8,
    parameter int UNIT_CYCLES = 4,
    parameter int QUIET_UNITS = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_active,
    input logic              tx_inhibit,
    input logic [CODE_W-1:0] cur_code
);
    int run_cnt;
    int q_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= 0;
            q_cnt   <= 0;
        end else begin
            run_cnt <= (tx_active && !tx_inhibit) ? run_cnt + 1 : 0;
            q_cnt   <= tx_inhibit ? q_cnt + 1 : 0;
        end
    end

    // R1
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_code == '0 && !tx_inhibit) |=> !tx_inhibit);

    // R2
    trip_time_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_inhibit) |-> (run_cnt == int'(cur_code) * UNIT_CYCLES));

    // R4
    quiet_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_inhibit) |-> (q_cnt == QUIET_UNITS * UNIT_CYCLES));

    // R5
    gap_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_active && !tx_inhibit) |=> !tx_inhibit);

    // R7
    idle_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_code != $past(cur_code)) |-> $past(!tx_active && !tx_inhibit));
endmodule

bind jabber_inhibitor jab_checker #(
    .CODE_W      (CODE_W),
    .UNIT_CYCLES (UNIT_CYCLES),
    .QUIET_UNITS (QUIET_UNITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_active  (tx_active),
    .tx_inhibit (tx_inhibit),
    .cur_code   (code_q)
);

// File: tb/jabber_inhibitor_test.sv
`timescale 1ns/1ps
module jabber_inhibitor_test;
    localparam int U = 4;   // CLK_KHZ=2 -> 4 cycles per unit
    localparam int Q = 5;   // QUIET_MS=10 -> 5 units

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_active = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_code = 8'h00;
    logic tx_inhibit, cd;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    jabber_inhibitor #(.CLK_KHZ(2), .QUIET_MS(10), .CODE_W(8)) uut (
        .clk(clk), .rst(rst), .tx_active(tx_active), .cfg_we(cfg_we),
        .cfg_code(cfg_code), .tx_inhibit(tx_inhibit), .cd(cd)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_code(input logic [7:0] c);
        cfg_we = 1'b1; cfg_code = c;
        edges(1);
        cfg_we = 1'b0;
    endtask

    task automatic settle();
        tx_active = 1'b0;
        edges(Q * U + 5);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        edges(3);
        rst = 1'b0;
        edges(1);
        chk("R8 inhibit after reset", tx_inhibit, 1'b0);
        chk("R8 cd after reset", cd, 1'b0);
        tx_active = 1'b1;
        edges(60);
        chk("R8 reset code disabled", tx_inhibit, 1'b0);
        settle();
    endtask

    task automatic t_disabled();
        wr_code(8'd0);
        tx_active = 1'b1;
        edges(300);
        chk("R1 inhibit with code 0", tx_inhibit, 1'b0);
        chk("R1 cd with code 0", cd, 1'b0);
        settle();
    endtask

    task automatic t_trip(input int code);
        wr_code(code[7:0]);
        tx_active = 1'b1;
        edges(code * U - 1);
        chk("R2 no trip one edge early", tx_inhibit, 1'b0);
        edges(1);
        chk("R2 trip at limit", tx_inhibit, 1'b1);
        chk("R3 cd with trip", cd, 1'b1);
        settle();
    endtask

    task automatic t_quiet();
        wr_code(8'd3);
        tx_active = 1'b1;
        edges(3 * U);
        chk("R2 trip code 3", tx_inhibit, 1'b1);
        edges(5);
        wr_code(8'd1);            // must be discarded during silence
        edges(Q * U - 7);
        chk("R4 inhibit held in quiet", tx_inhibit, 1'b1);
        chk("R4 cd held in quiet", cd, 1'b1);
        edges(1);
        chk("R4 inhibit released", tx_inhibit, 1'b0);
        chk("R4 cd released", cd, 1'b0);
        edges(3 * U - 1);
        chk("R6/R7 fresh timer, write ignored", tx_inhibit, 1'b0);
        edges(1);
        chk("R6 retrip after full limit", tx_inhibit, 1'b1);
        settle();
    endtask

    task automatic t_gap();
        wr_code(8'd2);
        tx_active = 1'b1;
        edges(2 * U - 1);
        chk("R5 before gap", tx_inhibit, 1'b0);
        tx_active = 1'b0;
        edges(1);
        chk("R5 during gap", tx_inhibit, 1'b0);
        tx_active = 1'b1;
        edges(2 * U - 1);
        chk("R5 timer cleared by gap", tx_inhibit, 1'b0);
        edges(1);
        chk("R5 trip after full run", tx_inhibit, 1'b1);
        settle();
    endtask

    task automatic t_busy_write();
        wr_code(8'd3);
        tx_active = 1'b1;
        edges(2);
        wr_code(8'd1);            // during transmission: discarded
        edges(3 * U - 4);
        chk("R7 busy write ignored", tx_inhibit, 1'b0);
        edges(1);
        chk("R7 trip uses old code", tx_inhibit, 1'b1);
        settle();
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        edges(1);
        t_reset();
        t_disabled();
        t_trip(3);
        t_quiet();
        t_gap();
        t_trip(1);
        t_trip(255);
        t_busy_write();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule